// File: doc/BRIEF.md
# Quotient Estimator, 128-bit by 64-bit

This unit produces a quick 64-bit estimate of the quotient of a 128-bit dividend, given as a high word and a low word, divided by a normalized 64-bit divisor. The divisor has its most significant bit set. The estimate is never below the exact truncated quotient and never more than two above it. A floating-point divider uses it as its first step and follows it with an exact correction stage. This unit does not compute the remainder and does not do the final correction.

An operation begins when `start` is pulsed while the unit is idle. The operands are captured on that cycle. `busy` stays high until the result has been delivered, and `done` marks the single cycle in which the result first appears. The quotient is built as two 32-bit digits. A serial restoring divide finds each digit, dividing by the top 32 bits of the divisor. Between the two digits, a serial shift-add multiply forms the partial remainder, and a short add-back loop repairs an upper digit that came out too large. When the divisor is not greater than the high dividend word, the unit skips all of this and returns all ones right away.

Top module: `quot_est128`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `done` are 0 and `quot` is 0.
- R2: `start` is taken only while `busy` is 0. A `start` pulse during an operation does not change that operation's result and does not produce an extra `done`.
- R3: If `den` <= `num_hi` when `start` is accepted, `done` is high in the next cycle with `quot` = 0xFFFFFFFFFFFFFFFF.
- R4: Take q as floor((`num_hi`·2^64 + `num_lo`) / `den`), with `den` bit 63 = 1 and `den` > `num_hi`. Then q <= `quot` <= q+2.
- R5: `done` is high for exactly one cycle per accepted operation.
- R6: `done` rises no later than 110 clock cycles after the cycle in which `start` was accepted.
- R7: When `den`[63:32]·2^32 <= `num_hi` < `den`, the upper digit is taken as 0xFFFFFFFF without dividing, and the R4 bound still holds.
- R8: An upper digit that makes the partial remainder negative is lowered by one per cycle, with the aligned divisor added back each time. This happens at most twice, and the result meets the R4 bound.
- R9: After `done`, `quot` keeps its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; taken only when idle |
| num_hi | input | 64 | Upper word of the dividend |
| num_lo | input | 64 | Lower word of the dividend |
| den | input | 64 | Divisor, bit 63 expected set |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle strobe: `quot` is valid |
| quot | output | 64 | Quotient estimate |

## Verification
Random normalized divisors with high words below the divisor test the q..q+2 bound in general, against an exact 128-bit division. A divisor of 2^63 makes the 32-bit top of the divisor an exact stand-in for the whole divisor. Divisors whose low half is all ones make the upper digit overshoot, which separates a correct add-back loop from a missing or miscounted one. A high word at or above the divisor's top half shifted up takes the upper-digit saturation path. High words equal to and above the divisor take the early all-ones exit. A start pulse during a run, with saturating operands, shows whether operands leak into an operation already in progress.

// File: rtl/qest_pkg.sv
package qest_pkg;
    localparam int WORD    = 64;
    localparam int HALF    = WORD / 2;
    localparam int DWIDE   = 2 * WORD;
    localparam int LAT_MAX = 3 * HALF + 14;

    typedef logic [WORD-1:0]  word_t;
    typedef logic [HALF-1:0]  half_t;
    typedef logic [DWIDE-1:0] wide_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDIV,
        S_MUL,
        S_FIX,
        S_LDIV,
        S_DONE
    } qstate_e;

    typedef struct packed {
        word_t num_hi;
        word_t num_lo;
        word_t den;
    } qop_t;

    // A digit estimate overflows 32 bits when the divisor top, scaled up, fits in the partial dividend
    function automatic logic digit_saturates(half_t den_top, word_t part);
        return {den_top, {HALF{1'b0}}} <= part;
    endfunction
endpackage

// File: rtl/qest_udiv.sv
// Serial restoring divide: 2*DW-bit numerator over DW-bit divisor, DW-bit quotient.
// Precondition: numerator upper half below the divisor.
module qest_udiv #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [2*DW-1:0] num,
    input  logic [DW-1:0]   den,
    output logic            fin,
    output logic [DW-1:0]   quo
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] part_q, shf_q, dv_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, fin_q;
    logic [DW:0]   trial, diff;
    logic          take;

    always_comb begin
        trial = {part_q, shf_q[DW-1]};
        take  = trial >= {1'b0, dv_q};
        diff  = trial - {1'b0, dv_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            shf_q  <= '0;
            dv_q   <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                part_q <= num[2*DW-1:DW];
                shf_q  <= num[DW-1:0];
                dv_q   <= den;
                cnt_q  <= '0;
                run_q  <= 1'b1;
            end else if (run_q) begin
                part_q <= take ? diff[DW-1:0] : trial[DW-1:0];
                shf_q  <= {shf_q[DW-2:0], take};
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == CW'(DW - 1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin = fin_q;
    assign quo = shf_q;

    // R4: digit division is only launched when its quotient fits the digit
    p_div_pre_r4: assert property (@(posedge clk) disable iff (rst)
        go |-> (num[2*DW-1:DW] < den));
    // R4: the partial remainder stays below the divisor at every step
    p_div_partial_r4: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (part_q < dv_q));
endmodule

// File: rtl/qest_mul.sv
// Serial shift-add multiply: AW-bit multiplicand by BW-bit multiplier, one bit per cycle.
module qest_mul #(
    parameter int AW = 64,
    parameter int BW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [AW-1:0]      mcand,
    input  logic [BW-1:0]      mplier,
    output logic               fin,
    output logic [AW+BW-1:0]   prod
);
    localparam int PW = AW + BW;
    localparam int CW = $clog2(BW);

    logic [PW-1:0] acc_q, sh_q;
    logic [BW-1:0] m_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            sh_q  <= '0;
            m_q   <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                acc_q <= '0;
                sh_q  <= {{BW{1'b0}}, mcand};
                m_q   <= mplier;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (m_q[0]) acc_q <= acc_q + sh_q;
                sh_q  <= sh_q << 1;
                m_q   <= m_q >> 1;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(BW - 1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin  = fin_q;
    assign prod = acc_q;

    // R4: every multiplier bit has been consumed when the product is offered
    p_mul_consumed_r4: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> (m_q == '0));
endmodule

// File: rtl/quot_est128.sv
module quot_est128
    import qest_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [63:0] num_hi,
    input  logic [63:0] num_lo,
    input  logic [63:0] den,
    output logic        busy,
    output logic        done,
    output logic [63:0] quot
);
    localparam int MIDLO = HALF;
    localparam int MIDHI = WORD + HALF - 1;

    qstate_e st_q;
    qop_t    op_q;
    half_t   zh_q;
    wide_t   rem_q;
    word_t   quot_q;
    logic    dgo_q, mgo_q;

    half_t            den_top;
    word_t            rem_mid;
    wide_t            align_den;
    word_t            div_num;
    logic             dfin, mfin;
    half_t            dquo;
    logic [WORD+HALF-1:0] mprod;

    always_comb begin
        den_top   = op_q.den[WORD-1:HALF];
        rem_mid   = rem_q[MIDHI:MIDLO];
        align_den = {{HALF{1'b0}}, op_q.den, {HALF{1'b0}}};
        div_num   = (st_q == S_LDIV) ? rem_mid : op_q.num_hi;
    end

    qest_udiv #(.DW(HALF)) u_digit_div (
        .clk (clk),
        .rst (rst),
        .go  (dgo_q),
        .num (div_num),
        .den (den_top),
        .fin (dfin),
        .quo (dquo)
    );

    qest_mul #(.AW(WORD), .BW(HALF)) u_part_mul (
        .clk    (clk),
        .rst    (rst),
        .go     (mgo_q),
        .mcand  (op_q.den),
        .mplier (zh_q),
        .fin    (mfin),
        .prod   (mprod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            op_q   <= '0;
            zh_q   <= '0;
            rem_q  <= '0;
            quot_q <= '0;
            dgo_q  <= 1'b0;
            mgo_q  <= 1'b0;
        end else begin
            dgo_q <= 1'b0;
            mgo_q <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    op_q <= '{num_hi: num_hi, num_lo: num_lo, den: den};
                    if (den <= num_hi) begin
                        quot_q <= '1;
                        st_q   <= S_DONE;
                    end else if (digit_saturates(den[WORD-1:HALF], num_hi)) begin
                        zh_q  <= '1;
                        mgo_q <= 1'b1;
                        st_q  <= S_MUL;
                    end else begin
                        dgo_q <= 1'b1;
                        st_q  <= S_HDIV;
                    end
                end
                S_HDIV: if (dfin) begin
                    zh_q  <= dquo;
                    mgo_q <= 1'b1;
                    st_q  <= S_MUL;
                end
                S_MUL: if (mfin) begin
                    rem_q <= {op_q.num_hi, op_q.num_lo} - {mprod, {HALF{1'b0}}};
                    st_q  <= S_FIX;
                end
                S_FIX: begin
                    if (rem_q[DWIDE-1]) begin
                        rem_q <= rem_q + align_den;
                        zh_q  <= zh_q - 1'b1;
                    end else if (digit_saturates(den_top, rem_mid)) begin
                        quot_q <= {zh_q, {HALF{1'b1}}};
                        st_q   <= S_DONE;
                    end else begin
                        dgo_q <= 1'b1;
                        st_q  <= S_LDIV;
                    end
                end
                S_LDIV: if (dfin) begin
                    quot_q <= {zh_q, dquo};
                    st_q   <= S_DONE;
                end
                S_DONE: st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy = (st_q != S_IDLE);
    assign done = (st_q == S_DONE);
    assign quot = quot_q;

    // Checker state: cycles since start and add-back steps taken
    logic [7:0] lat_q;
    logic [2:0] fix_n_q;
    always_ff @(posedge clk) begin
        if (rst || st_q == S_IDLE) begin
            lat_q   <= '0;
            fix_n_q <= '0;
        end else begin
            lat_q <= lat_q + 1'b1;
            if (st_q == S_FIX && rem_q[DWIDE-1]) fix_n_q <= fix_n_q + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && quot == '0));
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(op_q));
    p_sat_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && den <= num_hi) |=> (done && quot == '1));
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lat_q < 8'(LAT_MAX)));
    p_upper_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && den > num_hi && digit_saturates(den[WORD-1:HALF], num_hi))
        |=> (st_q == S_MUL && zh_q == '1));
    p_addback_limit_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (fix_n_q <= 3'd2));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(quot));
endmodule

// File: tb/quot_est128_tb_top.sv
`timescale 1ns/1ps
module quot_est128_tb_top;
    logic        clk = 1'b0;
    logic        rst, start;
    logic [63:0] hi, lo, dv;
    logic        busy, done;
    logic [63:0] quot;

    always #4 clk = ~clk;

    quot_est128 dut_i (
        .clk(clk), .rst(rst), .start(start),
        .num_hi(hi), .num_lo(lo), .den(dv),
        .busy(busy), .done(done), .quot(quot)
    );

    typedef struct {
        logic [63:0] hi;
        logic [63:0] lo;
        logic [63:0] dv;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    logic  prev_done = 1'b0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pop expected item on each done and compare
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                chk(!prev_done, "R5", "done longer than one cycle", 128'(prev_done), 128'd0);
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected done", 128'(quot), 128'd0);
                end else begin
                    item_t it;
                    logic [127:0] num, q;
                    it  = sb_q.pop_front();
                    num = {it.hi, it.lo};
                    if (it.hi >= it.dv) begin
                        chk(quot == '1, "R3", "saturated result", 128'(quot), 128'(64'hFFFF_FFFF_FFFF_FFFF));
                    end else begin
                        q = num / {64'd0, it.dv};
                        chk(({64'd0, quot} >= q) && ({64'd0, quot} <= q + 128'd2),
                            it.tag, "q..q+2 bound", 128'(quot), q);
                    end
                end
            end
            prev_done = done;
        end
    end

    task automatic send(input logic [63:0] h, input logic [63:0] l,
                        input logic [63:0] d, input string tag);
        int t0;
        item_t it;
        logic [63:0] held;
        while (busy) @(negedge clk);
        it.hi = h; it.lo = l; it.dv = d; it.tag = tag;
        sb_q.push_back(it);
        hi = h; lo = l; dv = d; start = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk((cyc - t0) <= 110, "R6", "latency", 128'(cyc - t0), 128'd110);
        if (h >= d) chk((cyc - t0) == 1, "R3", "saturation latency", 128'(cyc - t0), 128'd1);
        held = quot;
        repeat (6) @(negedge clk);
        chk(quot == held, "R9", "result held", 128'(quot), 128'(held));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] rd, rh, rl, held;
        rst = 1'b1; start = 1'b0; hi = '0; lo = '0; dv = '0;
        repeat (3) @(negedge clk);
        chk(!busy, "R1", "busy in reset", 128'(busy), 128'd0);
        chk(!done, "R1", "done in reset", 128'(done), 128'd0);
        chk(quot == '0, "R1", "quot in reset", 128'(quot), 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && quot == '0, "R1", "idle after reset", 128'(quot), 128'd0);

        // Directed cases
        send(64'd0, 64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0000, "R4");
        send(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R4");
        send(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
        send(64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_FFFF_FFFF, "R7");
        send(64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 64'h8000_0001_FFFF_FFFF, "R8");
        send(64'h8000_0000_7FFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000_FFFF_FFFF, "R8");
        send(64'hC000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hC000_0000_FFFF_FFFF, "R8");
        send(64'h9000_0000_0000_0000, 64'h5, 64'h9000_0000_0000_0000, "R3");
        send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h8000_0000_0000_0001, "R3");

        // R2: start during an operation is ignored
        while (busy) @(negedge clk);
        begin
            item_t it;
            it.hi = 64'h0; it.lo = 64'h0000_0000_0000_0100; it.dv = 64'h8000_0000_0000_0000; it.tag = "R2";
            sb_q.push_back(it);
            hi = it.hi; lo = it.lo; dv = it.dv; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            hi = 64'hFFFF_FFFF_FFFF_FFFF; dv = 64'h8000_0000_0000_0000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            held = quot;
            repeat (130) @(negedge clk);
            chk(sb_q.size() == 0 && quot == held && !busy, "R2", "stray start left no trace",
                128'(quot), 128'(held));
        end

        // Random normalized divisors, some with heavy low halves for add-back
        for (int i = 0; i < 40; i++) begin
            rd = {$urandom, $urandom};
            rd[63] = 1'b1;
            if (i % 3 == 0) rd[31:0] = 32'hFFFF_FFFF;
            rh = {$urandom, $urandom};
            if (rh >= rd) rh = rh - rd;
            if (i % 5 == 0) rh = {rd[63:32], 32'h0};
            if (rh >= rd) rh = rd - 64'd1;
            rl = {$urandom, $urandom};
            send(rh, rl, rd, (i % 3 == 0) ? "R8" : "R4");
        end
        for (int i = 0; i < 4; i++) begin
            rd = {$urandom, $urandom};
            rd[63] = 1'b1;
            send(rd + 64'(i == 0 ? 0 : 0), {$urandom, $urandom}, rd, "R3");
        end

        repeat (4) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule